// File: doc/BRIEF.md
# Management Bus Master Controller

This block is a memory-mapped master for the two-wire PHY management bus. It runs one Clause 22 read or write frame at a time toward an external PHY or switch chip. A small register-bus slave decodes a 7-bit byte window. Software loads a PHY and register address into the address register. For a write it also loads the data word. It then writes a command word carrying a go bit and an access kind. While the frame is on the wire it polls a busy flag. When busy drops after a read, the captured value sits in the result register.

The clock line MDC is derived from the system clock through a programmable half-period divider. It toggles only while a frame is in flight and rests low otherwise. The data line is split into an output value and an output enable for an external tristate pad. During a read frame the block releases the line for the turnaround and the data bits. It samples the input at each rising MDC edge.

Top module: `mgmt_mdio_ctrl`

## Requirements
- R1: After reset the divider register reads 20 and the address, data, result and command registers read 0. MDC is low and the data line is not driven (enable 0).
- R2: The register window uses these byte offsets. 0x40 is the divider, bits [7:0]. 0x44 is the address register, with the PHY address in bits [12:8] and the register number in bits [4:0]. 0x48 is the write data, bits [15:0]. 0x4C is the read result, bits [15:0]. 0x50 is the command register: write bit 8 = go, write bit 0 = kind (0 read, 1 write), read bit 16 = busy, read bit 0 = kind of the last accepted command, read bit 8 = 0. Any other offset reads 0.
- R3: Busy reads 1 from the cycle after an accepted go command. It stays 1 for exactly 128*D cycles, where D is the divider value, with 0 treated as 1.
- R4: Each frame is 64 bits sent MSB first. It starts with 32 ones, then the bits 01. Next comes an opcode of 10 for read or 01 for write. Then follow the 5-bit PHY address, the 5-bit register number, 2 turnaround bits and 16 data bits.
- R5: A write frame drives all 64 bits. Its turnaround bits are 1 then 0, and its data field is the write data register.
- R6: A read frame drives bits 0..45 and releases the line (enable 0) for bits 46..63. The input is sampled at the rising MDC edges of bits 48..63, and the 16 samples, first sample as MSB, appear in the result register when busy falls.
- R7: MDC is low for D system cycles and then high for D system cycles in each bit, giving exactly 64 rising edges per frame. MDC stays low when no frame is running.
- R8: The data output and its enable change only while MDC is low.
- R9: A go command written while busy is 1 is ignored. The frame in progress keeps its content and length.
- R10: Writes to the divider, address and write data registers while busy is 1 are ignored, and those registers keep their values.
- R11: The result register keeps its value across write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 7 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read access |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
Two things can land in the same cycle: a software register write, either a new go command or a configuration change, and the frame engine advancing a bit. The bench provokes this by issuing one-cycle writes to the command, divider, address and data registers in the middle of a running frame. It then judges the outcome in three ways. It compares the captured wire bits with the original frame. It compares the busy length with 128*D. It reads back the configuration registers to confirm their old values. A second coincidence is the falling MDC edge, which falls in the same cycle as the data line update. A monitor sampling between clock edges flags any change of output or enable while MDC is high.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFF_DIV  = 7'h40;
    localparam logic [ADDR_W-1:0] OFF_ADR  = 7'h44;
    localparam logic [ADDR_W-1:0] OFF_WDAT = 7'h48;
    localparam logic [ADDR_W-1:0] OFF_RES  = 7'h4C;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 7'h50;

    localparam int GO_BIT   = 8;
    localparam int KIND_BIT = 0;
    localparam int PHY_LSB  = 8;
    localparam int REG_LSB  = 0;

    localparam int FRAME_BITS = 64;
    localparam logic [5:0] IDX_TA   = 6'd46;
    localparam logic [5:0] IDX_DATA = 6'd48;
    localparam logic [5:0] IDX_LAST = 6'd63;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input acc_t        kind,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] data
    );
        logic [1:0] op;
        logic [1:0] ta;
        logic [15:0] body;
        op   = (kind == ACC_WRITE) ? 2'b01 : 2'b10;
        ta   = (kind == ACC_WRITE) ? 2'b10 : 2'b11;
        body = (kind == ACC_WRITE) ? data  : 16'hFFFF;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_ctl_regs.sv
module mdio_ctl_regs
    import mdio_ctl_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy_i,
    input  logic              rd_done_i,
    input  logic [15:0]       cap_i,
    output logic              start_o,
    output acc_t              start_kind_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [4:0]        phy_o,
    output logic [4:0]        reg_o,
    output logic [15:0]       wdat_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [4:0]       phy;
        logic [4:0]       regn;
        logic [15:0]      wdat;
        logic [15:0]      res;
        acc_t             kind;
    } regs_t;

    regs_t q, d;
    logic  wr_ok;
    wire   unused_hi = ^bus_wdata[31:16];

    assign wr_ok        = bus_sel && bus_wr;
    assign start_o      = wr_ok && (bus_addr == OFF_CMD) && bus_wdata[GO_BIT] && !busy_i;
    assign start_kind_o = acc_t'(bus_wdata[KIND_BIT]);

    always_comb begin
        d = q;
        if (wr_ok && !busy_i) begin
            case (bus_addr)
                OFF_DIV: d.div = bus_wdata[DIV_W-1:0];
                OFF_ADR: begin
                    d.phy  = bus_wdata[PHY_LSB+4:PHY_LSB];
                    d.regn = bus_wdata[REG_LSB+4:REG_LSB];
                end
                OFF_WDAT: d.wdat = bus_wdata[15:0];
                default: ;
            endcase
        end
        if (start_o) begin
            d.kind = start_kind_o;
        end
        if (rd_done_i) begin
            d.res = cap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{div: DIV_W'(DIV_RST), phy: '0, regn: '0, wdat: '0, res: '0, kind: ACC_READ};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFF_DIV:  bus_rdata = 32'(q.div);
                OFF_ADR:  bus_rdata = {19'b0, q.phy, 3'b0, q.regn};
                OFF_WDAT: bus_rdata = {16'b0, q.wdat};
                OFF_RES:  bus_rdata = {16'b0, q.res};
                OFF_CMD:  bus_rdata = {15'b0, busy_i, 15'b0, q.kind};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign div_o  = q.div;
    assign phy_o  = q.phy;
    assign reg_o  = q.regn;
    assign wdat_o = q.wdat;

endmodule

// File: rtl/mdio_ctl_tick.sv
module mdio_ctl_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t            q, d;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    assign tick_o  = run_i && (q.cnt == div_eff - DIV_W'(1));

    always_comb begin
        d = q;
        if (!run_i || tick_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mdio_ctl_shifter.sv
module mdio_ctl_shifter
    import mdio_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  acc_t        kind_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdat_i,
    input  logic        tick_i,
    input  logic        mdio_i,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    output logic        busy_o,
    output logic        rd_done_o,
    output logic [15:0] cap_o
);

    typedef struct packed {
        logic                  busy;
        logic                  mdc;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] shr;
        logic                  rd;
        logic                  oe;
        logic [15:0]           cap;
    } shift_t;

    shift_t     q, d;
    logic [5:0] idx_nx;

    assign idx_nx = q.idx + 6'd1;

    always_comb begin
        d         = q;
        rd_done_o = 1'b0;
        if (start_i) begin
            d.busy = 1'b1;
            d.mdc  = 1'b0;
            d.idx  = '0;
            d.shr  = build_frame(kind_i, phy_i, reg_i, wdat_i);
            d.rd   = (kind_i == ACC_READ);
            d.oe   = 1'b1;
        end else if (q.busy && tick_i) begin
            if (!q.mdc) begin
                d.mdc = 1'b1;
                if (q.rd && (q.idx >= IDX_DATA)) begin
                    d.cap = {q.cap[14:0], mdio_i};
                end
            end else begin
                d.mdc = 1'b0;
                if (q.idx == IDX_LAST) begin
                    d.busy    = 1'b0;
                    d.shr     = '0;
                    d.oe      = 1'b0;
                    rd_done_o = q.rd;
                end else begin
                    d.idx = idx_nx;
                    d.shr = {q.shr[FRAME_BITS-2:0], 1'b0};
                    d.oe  = !(q.rd && (idx_nx >= IDX_TA));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mdc_o     = q.mdc;
    assign mdio_o    = q.shr[FRAME_BITS-1];
    assign mdio_oe_o = q.oe;
    assign busy_o    = q.busy;
    assign cap_o     = q.cap;

endmodule

// File: rtl/mgmt_mdio_ctrl.sv
module mgmt_mdio_ctrl
    import mdio_ctl_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [6:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic             busy;
    logic             rd_done;
    logic [15:0]      cap;
    logic             start;
    acc_t             start_kind;
    logic [DIV_W-1:0] div_val;
    logic [4:0]       phy_val;
    logic [4:0]       reg_val;
    logic [15:0]      wdat_val;
    logic             tick;

    mdio_ctl_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .busy_i       (busy),
        .rd_done_i    (rd_done),
        .cap_i        (cap),
        .start_o      (start),
        .start_kind_o (start_kind),
        .div_o        (div_val),
        .phy_o        (phy_val),
        .reg_o        (reg_val),
        .wdat_o       (wdat_val)
    );

    mdio_ctl_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (div_val),
        .tick_o (tick)
    );

    mdio_ctl_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .kind_i    (start_kind),
        .phy_i     (phy_val),
        .reg_i     (reg_val),
        .wdat_i    (wdat_val),
        .tick_i    (tick),
        .mdio_i    (mdio_i),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .busy_o    (busy),
        .rd_done_o (rd_done),
        .cap_o     (cap)
    );

endmodule

// File: rtl/mdio_ctl_checker.sv
module mdio_ctl_checker
    import mdio_ctl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [6:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] div_val,
    input logic [4:0]       phy_val
);

    logic [31:0] len_q;
    logic [31:0] exp_len;

    assign exp_len = 32'd128 * ((div_val == '0) ? 32'd1 : 32'(div_val));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else begin
            len_q <= busy ? len_q + 32'd1 : 32'd0;
        end
    end

    assert_busy_follows_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFF_CMD && bus_wdata[GO_BIT] && !busy) |=> busy);

    assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_q == exp_len));

    assert_line_quiet_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    assert_idle_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_addr_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_sel && bus_wr && bus_addr == OFF_ADR) |=> $stable(phy_val));

    assert_div_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_sel && bus_wr && bus_addr == OFF_DIV) |=> $stable(div_val));

endmodule

bind mgmt_mdio_ctrl mdio_ctl_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .div_val   (div_val),
    .phy_val   (phy_val)
);

// File: tb/mgmt_mdio_ctrl_test.sv
module mgmt_mdio_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    bit done = 1'b0;

    int          edge_cnt = 0;
    logic [63:0] seen_bits = '0;
    logic [63:0] seen_oe = '0;
    logic [15:0] phy_pat = '0;
    logic [15:0] last_res = '0;
    logic        prev_o = 1'b0;
    logic        prev_oe = 1'b0;

    mgmt_mdio_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: record the line at each rising MDC, present read data after each falling MDC
    always @(posedge mdc) begin
        if (edge_cnt < 64) begin
            seen_bits[63-edge_cnt] = mdio_o;
            seen_oe[63-edge_cnt]   = mdio_oe;
        end
        edge_cnt = edge_cnt + 1;
    end

    always @(negedge mdc) begin
        if (edge_cnt >= 48 && edge_cnt < 64) mdio_i = phy_pat[63-edge_cnt];
        else mdio_i = 1'b1;
    end

    // R8 monitor: sampled between edges, any line change must find MDC low
    always @(negedge clk) begin
        if (rst_n && ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) && mdc) glitches++;
        prev_o  = mdio_o;
        prev_oe = mdio_oe;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] v);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        v = rdata;
        sel = 1'b0;
    endtask

    // poke: 1 = issue go and config writes in the middle of the frame
    task automatic run_frame(input bit kind, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] data, input int div, input bit set_div,
                             input logic [15:0] pat, input bit poke);
        logic [63:0] exp_bits;
        logic [63:0] exp_oe;
        logic [31:0] v;
        int n;
        int d_eff;
        if (set_div) bus_write(7'h40, 32'(div));
        bus_write(7'h44, {19'b0, phy, 3'b0, rg});
        bus_write(7'h48, {16'b0, data});
        phy_pat  = pat;
        edge_cnt = 0;
        d_eff = (div == 0) ? 1 : div;
        exp_bits = {32'hFFFF_FFFF, 2'b01, kind ? 2'b01 : 2'b10, phy, rg,
                    kind ? 2'b10 : 2'b00, kind ? data : 16'h0};
        exp_oe = kind ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
        bus_write(7'h50, 32'h100 | 32'(kind));
        n = 0;
        bus_read(7'h50, v);
        check("R3 busy set one cycle after go", 64'(v[16]), 64'd1);
        check("R2 go bit reads zero", 64'(v[8]), 64'd0);
        check("R2 kind bit reads back", 64'(v[0]), 64'(kind));
        while (v[16] && n < 100000) begin
            n++;
            @(negedge clk);
            if (poke && n >= 40 && n <= 43) begin
                sel = 1'b1; wr = 1'b1;
                case (n)
                    40: begin addr = 7'h50; wdata = 32'h100 | 32'(!kind); end
                    41: begin addr = 7'h40; wdata = 32'd7; end
                    42: begin addr = 7'h44; wdata = {19'b0, ~phy, 3'b0, ~rg}; end
                    default: begin addr = 7'h48; wdata = {16'b0, ~data}; end
                endcase
                @(negedge clk);
                sel = 1'b0; wr = 1'b0;
                n++;
            end
            bus_read(7'h50, v);
        end
        check(poke ? "R9 busy length unchanged by ignored go" : "R3 busy length",
              64'(n), 64'(128 * d_eff));
        check("R7 rising MDC edges per frame", 64'(edge_cnt), 64'd64);
        check(kind ? "R5 write frame bits" : "R4 read frame bits",
              seen_bits & exp_oe, exp_bits & exp_oe);
        check("R6 drive and release pattern", seen_oe, exp_oe);
        check("R7 MDC low when idle", 64'(mdc), 64'd0);
        bus_read(7'h4C, v);
        if (!kind) begin
            check("R6 read result", 64'(v[15:0]), 64'(pat));
            last_res = pat;
        end else begin
            check("R11 result kept over write frame", 64'(v[15:0]), 64'(last_res));
        end
        if (poke) begin
            bus_read(7'h40, v);
            check("R10 divider kept", 64'(v), 64'(div));
            bus_read(7'h44, v);
            check("R10 address kept", 64'(v), 64'({19'b0, phy, 3'b0, rg}));
            bus_read(7'h48, v);
            check("R10 write data kept", 64'(v), 64'(data));
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [4:0] phys [4];
        logic [4:0] regs [3];
        phys[0] = 5'd0; phys[1] = 5'd1; phys[2] = 5'd10; phys[3] = 5'd31;
        regs[0] = 5'd0; regs[1] = 5'd5; regs[2] = 5'd31;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        bus_read(7'h40, v); check("R1 divider reset value", 64'(v), 64'd20);
        bus_read(7'h44, v); check("R1 address reset value", 64'(v), 64'd0);
        bus_read(7'h48, v); check("R1 write data reset value", 64'(v), 64'd0);
        bus_read(7'h4C, v); check("R1 result reset value", 64'(v), 64'd0);
        bus_read(7'h50, v); check("R1 command reset value", 64'(v), 64'd0);
        check("R1 MDC low", 64'(mdc), 64'd0);
        check("R1 line released", 64'(mdio_oe), 64'd0);
        bus_read(7'h60, v); check("R2 unmapped offset reads zero", 64'(v), 64'd0);
        bus_read(7'h00, v); check("R2 offset zero reads zero", 64'(v), 64'd0);

        // default divider frame (R3, R7 at D = 20)
        run_frame(1'b0, 5'd3, 5'd2, 16'h0, 20, 1'b0, 16'hBEEF, 1'b0);

        // sweep over divider, address, register and kind
        for (int dv = 1; dv <= 3; dv++) begin
            for (int p = 0; p < 4; p++) begin
                for (int r = 0; r < 3; r++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [15:0] dat;
                        dat = 16'hA5C3 ^ 16'(32'(phys[p]) * 1031 + 32'(regs[r]) * 77 + dv);
                        run_frame(k[0], phys[p], regs[r], dat, dv, 1'b1,
                                  {dat[7:0], ~dat[15:8]}, 1'b0);
                    end
                end
            end
        end

        // divider 0 behaves as 1
        run_frame(1'b0, 5'd17, 5'd9, 16'h0, 0, 1'b1, 16'h8001, 1'b0);

        // R9 and R10: go and config writes during a frame, both kinds
        run_frame(1'b1, 5'd6, 5'd12, 16'h3C5A, 2, 1'b1, 16'h0, 1'b1);
        run_frame(1'b0, 5'd21, 5'd30, 16'h1234, 3, 1'b1, 16'h7E81, 1'b1);

        check("R8 line changes only while MDC low", 64'(glitches), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule